// File: doc/BRIEF.md
# AXI4 Write Channel Protocol Checker

This block is a synthesizable monitor for the write address and write data channels of one AXI4 interface. It only watches: every input is sampled and nothing is driven back onto the bus. Each burst length accepted on the address channel goes into a small queue. A beat position counter then follows the data channel against the queue head and checks that the last-beat marker comes on exactly the final beat. Beats are counted only on cycles where valid and ready are both high.

A second path watches the data channel while it is stalled. Once a beat is offered and not yet taken, the valid line and the whole payload (data, strobes, last marker) must stay unchanged into the next cycle. Any change sets a flag, even when it looks harmless.

Each kind of violation has its own flag, and a flag stays set until reset. A saturating counter totals every violation seen. The block is meant to sit beside a master in simulation or on silicon, where it catches data-channel sequencing bugs.

Top module: `axi_wr_checker`

## Requirements
- R1: An accepted address length value L (a cycle with aw_valid and aw_ready both high) stands for L+1 data beats, so L = 0 is a single beat. A data beat counts only on a cycle where w_valid and w_ready are both high.
- R2: A burst whose beats carry w_last low on every beat except the final one, and high on the final one, raises no flag. This holds with stalls inside the burst.
- R3: A counted beat with w_last high before the final beat of the queue-head burst sets err_last_early after that clock edge. That burst then ends, and the next queued length is used for the following beats.
- R4: A final beat (including the only beat of an L = 0 burst) that completes with w_last low sets err_last_missing after that clock edge. That burst then ends.
- R5: A cycle with w_ready high and w_valid low is not a beat and raises no flag.
- R6: If a cycle has w_valid high and w_ready low, then on the next cycle a low w_valid, or any change in w_data, w_strb or w_last, sets err_unstable. An unchanged payload across a stall raises no flag.
- R7: err_last_early, err_last_missing and err_unstable stay high once set, until reset.
- R8: err_count (8 bits) rises by the number of violations seen in each cycle and holds at 255 instead of wrapping.
- R9: While rst_n is low at a clock edge (synchronous, active low), the flags, the count, the length queue and the beat position are cleared. A length accepted before reset is therefore forgotten.
- R10: Up to four accepted lengths can be queued ahead of the data. Bursts are checked in the order their addresses were accepted.
- R11: A beat that arrives while no length is queued gets no last-marker check and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | input | 1 | Address channel ready |
| aw_len | input | 8 | Burst length, beats minus one |
| w_valid | input | 1 | Data channel valid |
| w_ready | input | 1 | Data channel ready |
| w_data | input | 128 | Write data |
| w_strb | input | 16 | Byte strobes |
| w_last | input | 1 | Last beat marker |
| err_last_early | output | 1 | Sticky: last marker came before the final beat |
| err_last_missing | output | 1 | Sticky: final beat completed without the last marker |
| err_unstable | output | 1 | Sticky: valid or payload changed during a stall |
| err_count | output | 8 | Saturating total of violations |

## Verification
The assertions assume that the master never has more than four addresses accepted and waiting for data. They also assume that a burst's address is accepted in a cycle before its first data beat. If either assumption breaks, the queue would drop a length or the beat would go unchecked. The stimulus sends every address on its own cycle ahead of its beats, and it keeps at most four outstanding. Stall, strobe, last-marker and valid-drop cases are run from a quiet cycle, so each violation is counted exactly once. The long saturation run has no address in flight.

// File: rtl/axi_wchk_pkg.sv
package axi_wchk_pkg;

   // Slot of each violation kind inside the hit and flag vectors
   typedef enum int unsigned {
      VIO_EARLY    = 0,
      VIO_MISSING  = 1,
      VIO_UNSTABLE = 2
   } vio_kind_e;

   localparam int unsigned NUM_VIO = 3;

endpackage

// File: rtl/wchk_len_fifo.sv
module wchk_len_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             push,
   input  logic [WIDTH-1:0]                 din,
   input  logic                             pop,
   output logic [WIDTH-1:0]                 dout,
   output logic                             empty,
   output logic                             full,
   output logic [$clog2(DEPTH+1)-1:0]       level
);

   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned LVL_W = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("wchk_len_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             pop_ok, push_ok;

   assign empty   = (level == '0);
   assign full    = (level == LVL_W'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
      end
   end

endmodule

// File: rtl/wchk_beat_tracker.sv
module wchk_beat_tracker #(
   parameter int unsigned LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             last,
   input  logic             have_burst,
   input  logic [LEN_W-1:0] exp_len,
   output logic [LEN_W-1:0] beat_idx,
   output logic             burst_done,
   output logic             last_early,
   output logic             last_missing
);

   logic act, at_final;

   always_comb begin
      act          = beat && have_burst;
      at_final     = (beat_idx == exp_len);
      last_early   = act && last && !at_final;
      last_missing = act && !last && at_final;
      burst_done   = act && (last || at_final);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_idx <= '0;
      end else if (burst_done) begin
         beat_idx <= '0;
      end else if (act) begin
         beat_idx <= beat_idx + 1'b1;
      end
   end

endmodule

// File: rtl/wchk_hold_mon.sv
module wchk_hold_mon #(
   parameter int unsigned PAY_W = 145
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             ready,
   input  logic [PAY_W-1:0] payload,
   output logic             broken
);

   logic             stalled_q;
   logic [PAY_W-1:0] pay_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stalled_q <= 1'b0;
         pay_q     <= '0;
      end else begin
         stalled_q <= valid && !ready;
         pay_q     <= payload;
      end
   end

   assign broken = stalled_q && (!valid || (payload != pay_q));

endmodule

// File: rtl/wchk_err_accum.sv
module wchk_err_accum #(
   parameter int unsigned NUM      = 3,
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM-1:0]   hit,
   output logic [NUM-1:0]   flags,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

   generate
      if ($clog2(NUM + 1) > CNT_W) begin : g_bad_cnt
         $error("wchk_err_accum: CNT_W too narrow for NUM");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM; i++) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags[i] <= 1'b0;
            end else if (hit[i]) begin
               flags[i] <= 1'b1;
            end
         end
      end
   endgenerate

   logic [CNT_W:0]   ones;
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      ones = '0;
      for (int i = 0; i < NUM; i++) begin
         ones = ones + (CNT_W+1)'(hit[i]);
      end
      sum = {1'b0, count} + ones;
   end

   generate
      if (SATURATE) begin : g_sat
         assign cnt_nxt = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
      end else begin : g_wrap
         assign cnt_nxt = sum[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         count <= cnt_nxt;
      end
   end

endmodule

// File: rtl/axi_wr_checker.sv
module axi_wr_checker #(
   parameter int unsigned DATA_W    = 128,
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned Q_DEPTH   = 4,
   parameter int unsigned CNT_W     = 8,
   parameter bit          SATURATE  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                aw_valid,
   input  logic                aw_ready,
   input  logic [LEN_W-1:0]    aw_len,
   input  logic                w_valid,
   input  logic                w_ready,
   input  logic [DATA_W-1:0]   w_data,
   input  logic [DATA_W/8-1:0] w_strb,
   input  logic                w_last,
   output logic                err_last_early,
   output logic                err_last_missing,
   output logic                err_unstable,
   output logic [CNT_W-1:0]    err_count
);

   import axi_wchk_pkg::*;

   localparam int unsigned STRB_W = DATA_W / 8;
   localparam int unsigned PAY_W  = DATA_W + STRB_W + 1;
   localparam int unsigned LVL_W  = $clog2(Q_DEPTH + 1);

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("axi_wr_checker: DATA_W must be a whole number of bytes");
      end
   endgenerate

   logic             aw_hs, w_hs;
   logic [LEN_W-1:0] head_len;
   logic             fifo_empty, fifo_full;
   logic [LVL_W-1:0] fifo_level;
   logic [LEN_W-1:0] trk_idx;
   logic             trk_done, trk_early, trk_missing;
   logic             hold_broken;
   logic [NUM_VIO-1:0] vio_hit, vio_flags;

   assign aw_hs = aw_valid && aw_ready;
   assign w_hs  = w_valid && w_ready;

   wchk_len_fifo #(
      .WIDTH (LEN_W),
      .DEPTH (Q_DEPTH)
   ) u_len_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (aw_hs),
      .din   (aw_len),
      .pop   (trk_done),
      .dout  (head_len),
      .empty (fifo_empty),
      .full  (fifo_full),
      .level (fifo_level)
   );

   wchk_beat_tracker #(
      .LEN_W (LEN_W)
   ) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .beat         (w_hs),
      .last         (w_last),
      .have_burst   (!fifo_empty),
      .exp_len      (head_len),
      .beat_idx     (trk_idx),
      .burst_done   (trk_done),
      .last_early   (trk_early),
      .last_missing (trk_missing)
   );

   wchk_hold_mon #(
      .PAY_W (PAY_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (w_valid),
      .ready   (w_ready),
      .payload ({w_last, w_strb, w_data}),
      .broken  (hold_broken)
   );

   always_comb begin
      vio_hit = '0;
      vio_hit[VIO_EARLY]    = trk_early;
      vio_hit[VIO_MISSING]  = trk_missing;
      vio_hit[VIO_UNSTABLE] = hold_broken;
   end

   wchk_err_accum #(
      .NUM      (NUM_VIO),
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (vio_hit),
      .flags (vio_flags),
      .count (err_count)
   );

   assign err_last_early   = vio_flags[VIO_EARLY];
   assign err_last_missing = vio_flags[VIO_MISSING];
   assign err_unstable     = vio_flags[VIO_UNSTABLE];

endmodule

// File: rtl/axi_wr_checker_sva.sv
module axi_wr_checker_sva #(
   parameter int unsigned DATA_W  = 128,
   parameter int unsigned LEN_W   = 8,
   parameter int unsigned Q_DEPTH = 4,
   parameter int unsigned CNT_W   = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       aw_valid,
   input logic                       aw_ready,
   input logic                       w_valid,
   input logic                       w_ready,
   input logic [DATA_W-1:0]          w_data,
   input logic [DATA_W/8-1:0]        w_strb,
   input logic                       w_last,
   input logic [LEN_W-1:0]           head_len,
   input logic [LEN_W-1:0]           trk_idx,
   input logic                       fifo_empty,
   input logic                       fifo_full,
   input logic [$clog2(Q_DEPTH+1)-1:0] fifo_level,
   input logic                       err_last_early,
   input logic                       err_last_missing,
   input logic                       err_unstable,
   input logic [CNT_W-1:0]           err_count
);

   localparam int unsigned PAY_W = DATA_W + DATA_W/8 + 1;

   logic             seen_stall;
   logic [PAY_W-1:0] seen_pay;
   logic             beat;

   assign beat = w_valid && w_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_stall <= 1'b0;
         seen_pay   <= '0;
      end else begin
         seen_stall <= w_valid && !w_ready;
         seen_pay   <= {w_last, w_strb, w_data};
      end
   end

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= ($clog2(Q_DEPTH+1))'(Q_DEPTH));

   // R10
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !(aw_valid && aw_ready));

   // R3
   early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !fifo_empty && w_last && trk_idx != head_len) |=> err_last_early);

   // R4
   missing_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !fifo_empty && !w_last && trk_idx == head_len) |=> err_last_missing);

   // R6
   unstable_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_stall && (!w_valid || {w_last, w_strb, w_data} != seen_pay)) |=> err_unstable);

   // R7
   early_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_last_early |=> err_last_early);

   // R7
   missing_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_last_missing |=> err_last_missing);

   // R7
   unstable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_unstable |=> err_unstable);

   // R8
   count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count != '0) |=> (err_count >= $past(err_count)));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (err_count == '0 && !err_last_early && !err_last_missing
                  && !err_unstable && fifo_empty));

   // R11
   no_burst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && fifo_empty && !seen_stall && !err_last_early && !err_last_missing)
         |=> (!err_last_early && !err_last_missing));

endmodule

bind axi_wr_checker axi_wr_checker_sva #(
   .DATA_W  (DATA_W),
   .LEN_W   (LEN_W),
   .Q_DEPTH (Q_DEPTH),
   .CNT_W   (CNT_W)
) u_sva (
   .clk              (clk),
   .rst_n            (rst_n),
   .aw_valid         (aw_valid),
   .aw_ready         (aw_ready),
   .w_valid          (w_valid),
   .w_ready          (w_ready),
   .w_data           (w_data),
   .w_strb           (w_strb),
   .w_last           (w_last),
   .head_len         (head_len),
   .trk_idx          (trk_idx),
   .fifo_empty       (fifo_empty),
   .fifo_full        (fifo_full),
   .fifo_level       (fifo_level),
   .err_last_early   (err_last_early),
   .err_last_missing (err_last_missing),
   .err_unstable     (err_unstable),
   .err_count        (err_count)
);

// File: tb/tb_axi_wr_checker.sv
`timescale 1ns/1ps
module tb_axi_wr_checker;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         aw_valid = 1'b0, aw_ready = 1'b0;
   logic [7:0]   aw_len = '0;
   logic         w_valid = 1'b0, w_ready = 1'b0;
   logic [127:0] w_data = '0;
   logic [15:0]  w_strb = '0;
   logic         w_last = 1'b0;
   logic         err_last_early, err_last_missing, err_unstable;
   logic [7:0]   err_count;

   always #2.5 clk = ~clk;

   axi_wr_checker dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .aw_valid         (aw_valid),
      .aw_ready         (aw_ready),
      .aw_len           (aw_len),
      .w_valid          (w_valid),
      .w_ready          (w_ready),
      .w_data           (w_data),
      .w_strb           (w_strb),
      .w_last           (w_last),
      .err_last_early   (err_last_early),
      .err_last_missing (err_last_missing),
      .err_unstable     (err_unstable),
      .err_count        (err_count)
   );

   typedef struct {
      bit    e;
      bit    m;
      bit    s;
      int    cnt;
      string tag;
   } exp_t;

   exp_t  sb[$];
   int    total = 0;
   int    bad = 0;
   bit    mdl_e, mdl_m, mdl_s;
   int    mdl_cnt;
   logic  rst_drv = 1'b0;
   bit    finished = 1'b0;

   // Driver: one call is one clock cycle; expected outputs after the edge are queued
   task automatic cyc(input bit awv, input logic [7:0] len,
                      input bit wv, input bit wr, input logic [127:0] d,
                      input logic [15:0] s, input bit l,
                      input bit ve, input bit vm, input bit vs, input string tag);
      exp_t x;
      @(negedge clk);
      rst_n    = rst_drv;
      aw_valid = awv;
      aw_ready = awv;
      aw_len   = len;
      w_valid  = wv;
      w_ready  = wr;
      w_data   = d;
      w_strb   = s;
      w_last   = l;
      if (!rst_drv) begin
         mdl_e = 0; mdl_m = 0; mdl_s = 0; mdl_cnt = 0;
      end else begin
         mdl_e = mdl_e | ve;
         mdl_m = mdl_m | vm;
         mdl_s = mdl_s | vs;
         mdl_cnt = mdl_cnt + int'(ve) + int'(vm) + int'(vs);
         if (mdl_cnt > 255) mdl_cnt = 255;
      end
      x.e = mdl_e; x.m = mdl_m; x.s = mdl_s; x.cnt = mdl_cnt; x.tag = tag;
      sb.push_back(x);
      @(posedge clk);
   endtask

   task automatic idle(input string tag);
      cyc(0, 8'd0, 0, 0, '0, '0, 0, 0, 0, 0, tag);
   endtask

   task automatic addr(input logic [7:0] len, input string tag);
      cyc(1, len, 0, 0, '0, '0, 0, 0, 0, 0, tag);
   endtask

   task automatic beat(input logic [127:0] d, input bit l,
                       input bit ve, input bit vm, input string tag);
      cyc(0, 8'd0, 1, 1, d, 16'hFFFF, l, ve, vm, 0, tag);
   endtask

   task automatic do_reset();
      rst_drv = 1'b0;
      idle("R9");
      idle("R9");
      rst_drv = 1'b1;
   endtask

   // Monitor: pops one expectation per clock, after the outputs settle
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            total++;
            if (err_last_early !== x.e || err_last_missing !== x.m ||
                err_unstable !== x.s || int'(err_count) != x.cnt) begin
               bad++;
               $display("FAIL %s: early/missing/unstable/count = %b/%b/%b/%0d expected %b/%b/%b/%0d",
                        x.tag, err_last_early, err_last_missing, err_unstable, err_count,
                        x.e, x.m, x.s, x.cnt);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not end, actual hung expected done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      do_reset();
      idle("R9");

      // R1 R2: single-beat burst with correct last marker
      addr(8'd0, "R1");
      beat(128'h11, 1, 0, 0, "R1");
      // R2 R5: four-beat burst with a stall and a ready-only gap
      addr(8'd3, "R2");
      beat(128'h20, 0, 0, 0, "R2");
      cyc(0, 8'd0, 1, 0, 128'h21, 16'hFFFF, 0, 0, 0, 0, "R2");
      cyc(0, 8'd0, 1, 0, 128'h21, 16'hFFFF, 0, 0, 0, 0, "R2");
      beat(128'h21, 0, 0, 0, "R2");
      cyc(0, 8'd0, 0, 1, '0, '0, 0, 0, 0, 0, "R5");
      cyc(0, 8'd0, 0, 1, '0, '0, 1, 0, 0, 0, "R5");
      beat(128'h22, 0, 0, 0, "R2");
      beat(128'h23, 1, 0, 0, "R2");
      idle("R2");

      // R3: last marker on the second beat of a three-beat burst
      addr(8'd2, "R3");
      beat(128'h30, 0, 0, 0, "R3");
      beat(128'h31, 1, 1, 0, "R3");
      // R3: next queued length is used after the early end
      addr(8'd0, "R3");
      beat(128'h32, 1, 0, 0, "R3");

      // R4: single beat with the marker low
      addr(8'd0, "R4");
      beat(128'h40, 0, 0, 1, "R4");
      addr(8'd1, "R4");
      beat(128'h41, 0, 0, 0, "R4");
      beat(128'h42, 1, 0, 0, "R4");
      // R4: two-beat burst missing its marker
      addr(8'd1, "R4");
      beat(128'h43, 0, 0, 0, "R4");
      beat(128'h44, 0, 0, 1, "R4");
      // R7: flags stay up through clean traffic
      addr(8'd0, "R7");
      beat(128'h45, 1, 0, 0, "R7");
      idle("R7");
      idle("R7");

      // R6: payload and valid changes during stalls
      do_reset();
      cyc(0, 8'd0, 1, 0, 128'hA1, 16'hFFFF, 0, 0, 0, 0, "R6");
      cyc(0, 8'd0, 1, 0, 128'hA2, 16'hFFFF, 0, 0, 0, 1, "R6");
      cyc(0, 8'd0, 1, 1, 128'hA2, 16'hFFFF, 0, 0, 0, 0, "R11");
      cyc(0, 8'd0, 1, 0, 128'hA3, 16'hFFFF, 0, 0, 0, 0, "R6");
      cyc(0, 8'd0, 1, 0, 128'hA3, 16'h00FF, 0, 0, 0, 1, "R6");
      cyc(0, 8'd0, 1, 0, 128'hA3, 16'h00FF, 1, 0, 0, 1, "R6");
      cyc(0, 8'd0, 0, 0, 128'hA3, 16'h00FF, 1, 0, 0, 1, "R6");
      idle("R6");
      cyc(0, 8'd0, 1, 0, 128'hA4, 16'h0F0F, 0, 0, 0, 0, "R6");
      cyc(0, 8'd0, 1, 0, 128'hA4, 16'h0F0F, 0, 0, 0, 0, "R6");
      cyc(0, 8'd0, 1, 1, 128'hA4, 16'h0F0F, 0, 0, 0, 0, "R6");
      idle("R7");

      // R11: beats with nothing queued
      do_reset();
      beat(128'hB0, 0, 0, 0, "R11");
      beat(128'hB1, 1, 0, 0, "R11");
      idle("R11");

      // R10: four lengths accepted ahead of the data
      do_reset();
      addr(8'd1, "R10");
      addr(8'd0, "R10");
      addr(8'd2, "R10");
      addr(8'd0, "R10");
      beat(128'hC0, 0, 0, 0, "R10");
      beat(128'hC1, 1, 0, 0, "R10");
      beat(128'hC2, 1, 0, 0, "R10");
      beat(128'hC3, 0, 0, 0, "R10");
      beat(128'hC4, 0, 0, 0, "R10");
      beat(128'hC5, 1, 0, 0, "R10");
      beat(128'hC6, 1, 0, 0, "R10");
      idle("R10");

      // R9: a length queued before reset is forgotten
      addr(8'd3, "R9");
      do_reset();
      beat(128'hD0, 1, 0, 0, "R9");
      idle("R9");

      // R8: long run of unstable cycles saturates the count
      do_reset();
      for (int k = 0; k < 300; k++) begin
         cyc(0, 8'd0, 1, 0, 128'(k + 1), 16'hFFFF, 0, 0, 0, (k > 0), "R8");
      end
      idle("R8");

      idle("end");
      #2;
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule